// File: doc/BRIEF.md
# Low-Speed Clock Source Selector

This block picks the timekeeping tick for the low-speed clock domain of a chip from one of two sources: an on-die RC oscillator or an external 32 kHz crystal. Both arrive as one-cycle enable strobes in the single system clock domain. The RC strobe passes through a fixed prescaler and then through a programmable divide-by-(N+1) stage. The crystal strobe passes through undivided. A registered mux then drives the selected tick out, and a second copy leaves through an output gate.

Software changes the source through a small register bus. A write to the control register takes effect only when the upper 16 bits of the data carry the unlock key. A failure monitor watches the external-failure detect input. When the crystal has been reported bad for a set number of consecutive cycles, the monitor returns the selection to the RC source, unless software has set the bypass bit.

The monitor is a three-state machine:
- `MON_OFF`: the crystal is not selected, or bypass is set.
- `MON_GOOD`: the crystal is selected and no failure is reported.
- `MON_SUSPECT`: failure samples are being counted.

Its transitions are:
- OFF→GOOD when the crystal becomes selected without bypass.
- GOOD→SUSPECT on the first failure sample.
- SUSPECT→GOOD when the detect input drops.
- Any state→OFF when the monitor disarms.
- SUSPECT (or GOOD, when `FAIL_CYCLES` is 1)→OFF with a trip, on the last failure sample of the run.

Top module: `lsclk_select`

## Requirements
- R1: After reset, all three registers read 0, and `tick_out` and `gated_out` are 0.
- R2: The register addresses are: control at 0, divider at 1, gate at 2. Address 3 reads 0. A control write is accepted only when `bus_wdata[31:16]` equals 16'h16AA; any other key leaves the control register unchanged. The control readback is: bit 0 = source (0 internal, 1 external), bit 4 = external enable, bit 15 = fallback bypass, all other bits 0. The divider readback is N in bits 4:0, other bits 0. The gate readback is the enable in bit 0, other bits 0.
- R3: With the internal source selected, `tick_out` pulses once per FIXED_DIV×(N+1) `int_tick` strobes. The pulse appears one cycle after the strobe that completes the count.
- R4: A write to the divider register restarts the divide-by-(N+1) count from zero. The fixed-prescaler phase is kept.
- R5: With the external source selected and bit 4 set, `tick_out` equals `ext_tick` delayed by one cycle. With bit 4 clear, `tick_out` stays 0.
- R6: With the external source selected and bypass clear, when `ext_fail` is sampled high on FAIL_CYCLES consecutive edges, control bit 0 clears at the last of those edges. Bit 4 is kept.
- R7: With bypass set, no run of `ext_fail` changes the selection.
- R8: `gated_out` equals `tick_out` when gate bit 0 is set, and is 0 otherwise.
- R9: A keyed control write on the same edge as a fallback trip wins over the trip.
- R10: A failure run shorter than FAIL_CYCLES, or a run broken by one low sample, causes no fallback, and the count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| int_tick | input | 1 | RC oscillator enable strobe |
| ext_tick | input | 1 | Crystal enable strobe |
| ext_fail | input | 1 | External oscillator failure detect |
| tick_out | output | 1 | Selected low-speed tick |
| gated_out | output | 1 | Tick copy through the output gate |

## Verification
Both tick outputs are registered. Each is due one clock after the cycle whose strobes, selection and divider count produce it. The bench therefore drives each cycle's inputs after a falling edge, advances its own model at the rising edge, and compares both outputs at the next falling edge. Register effects, including the fallback trip, take hold at the write or trip edge and appear on the combinational readback in the next half cycle. The bench reads the registers back only at falling edges with the write strobe low. The fallback is checked at the exact edge that completes the FAIL_CYCLES-long run, one sample short of it, and on the edge where it collides with a keyed write.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;

    localparam logic [15:0] CTRL_KEY = 16'h16AA;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_DIV  = 2'd1;
    localparam logic [1:0] ADR_GATE = 2'd2;

    localparam int BIT_SRC = 0;
    localparam int BIT_XEN = 4;
    localparam int BIT_BYP = 15;

    localparam int NDIV_W = 5;

    typedef enum logic [1:0] {
        MON_OFF,
        MON_GOOD,
        MON_SUSPECT
    } mon_state_t;

    typedef struct packed {
        logic bypass;
        logic ext_en;
        logic src_ext;
    } ctrl_t;

endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
    import lsclk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NW     = NDIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              trip,
    output ctrl_t             ctrl,
    output logic [NW-1:0]     ndiv,
    output logic              ndiv_wr,
    output logic              gate_en,
    output logic [DATA_W-1:0] rdata
);

    localparam int KEY_LSB = DATA_W - 16;

    logic key_ok;
    logic ctrl_wr;
    logic gate_wr;
    logic unused_wbits;

    assign key_ok  = (wdata[DATA_W-1:KEY_LSB] == CTRL_KEY);
    assign ctrl_wr = wr && (addr == ADR_CTRL) && key_ok;
    assign ndiv_wr = wr && (addr == ADR_DIV);
    assign gate_wr = wr && (addr == ADR_GATE);

    assign unused_wbits = ^{wdata[KEY_LSB-1:BIT_BYP+1], wdata[BIT_BYP-1:BIT_XEN+1],
                            wdata[BIT_XEN-1:NW]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.src_ext <= wdata[BIT_SRC];
            ctrl.ext_en  <= wdata[BIT_XEN];
            ctrl.bypass  <= wdata[BIT_BYP];
        end else if (trip) begin
            ctrl.src_ext <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ndiv    <= '0;
            gate_en <= 1'b0;
        end else begin
            if (ndiv_wr) ndiv    <= wdata[NW-1:0];
            if (gate_wr) gate_en <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: begin
                rdata[BIT_SRC] = ctrl.src_ext;
                rdata[BIT_XEN] = ctrl.ext_en;
                rdata[BIT_BYP] = ctrl.bypass;
            end
            ADR_DIV:  rdata[NW-1:0] = ndiv;
            ADR_GATE: rdata[0] = gate_en;
            default:  rdata = '0;
        endcase
    end

    // R2: a control write with a wrong key changes nothing
    a_r2_bad_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADR_CTRL && wdata[DATA_W-1:KEY_LSB] != CTRL_KEY && !trip)
        |=> $stable(ctrl));

    // R6: fallback only ever clears the source bit, never sets it
    a_r6_trip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !(wr && addr == ADR_CTRL)) |=> (!ctrl.src_ext && $stable(ctrl.ext_en)));

endmodule

// File: rtl/lsclk_fail_mon.sv
module lsclk_fail_mon
    import lsclk_pkg::*;
#(
    parameter int FAIL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_ext,
    input  logic bypass,
    input  logic ext_fail,
    output logic trip
);

    localparam int CW = (FAIL_CYCLES < 2) ? 1 : $clog2(FAIL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FAIL_CYCLES - 1);

    mon_state_t state, nxt_state;
    logic [CW-1:0] cnt, nxt_cnt, seen;
    logic armed;

    assign armed = src_ext && !bypass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MON_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    always_comb begin
        unique case (state)
            MON_SUSPECT: seen = cnt;
            MON_GOOD:    seen = '0;
            MON_OFF:     seen = '0;
            default:     seen = '0;
        endcase
    end

    always_comb begin
        nxt_state = MON_OFF;
        nxt_cnt   = '0;
        trip      = 1'b0;
        if (!armed) begin
            nxt_state = MON_OFF;
        end else if (!ext_fail) begin
            nxt_state = MON_GOOD;
        end else if (seen == LAST) begin
            trip      = 1'b1;
            nxt_state = MON_OFF;
        end else begin
            nxt_state = MON_SUSPECT;
            nxt_cnt   = seen + CW'(1);
        end
    end

    // R6: a trip only happens while armed and failing
    a_r6_trip_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> (src_ext && !bypass && ext_fail));

    // R10: a low detect sample always leaves the counting state
    a_r10_drop_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_fail |=> (state != MON_SUSPECT));

    // R7: bypass keeps the monitor idle
    a_r7_bypass_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> !trip);

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/lsclk_divider.sv
module lsclk_divider #(
    parameter int FIXED_DIV = 32,
    parameter int NW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_tick,
    input  logic [NW-1:0] ndiv,
    input  logic          ndiv_wr,
    output logic          div_pulse
);

    logic          pre_pulse;
    logic [NW-1:0] div_cnt;

    generate
        if (FIXED_DIV <= 1) begin : g_nopre
            assign pre_pulse = in_tick;
        end else begin : g_pre
            localparam int PW = $clog2(FIXED_DIV);
            localparam logic [PW-1:0] PRE_LAST = PW'(FIXED_DIV - 1);
            logic [PW-1:0] pre_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_cnt <= '0;
                end else if (in_tick) begin
                    pre_cnt <= (pre_cnt == PRE_LAST) ? '0 : pre_cnt + PW'(1);
                end
            end

            assign pre_pulse = in_tick && (pre_cnt == PRE_LAST);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (ndiv_wr) begin
            div_cnt <= '0;
        end else if (pre_pulse) begin
            div_cnt <= (div_cnt == ndiv) ? '0 : div_cnt + NW'(1);
        end
    end

    assign div_pulse = pre_pulse && (div_cnt == ndiv);

    // R3: the divided pulse never appears without a source strobe
    a_r3_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> in_tick);

    // R4: the divide count stays within the programmed range
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= ndiv);

endmodule

// File: rtl/lsclk_select.sv
module lsclk_select
    import lsclk_pkg::*;
#(
    parameter int FIXED_DIV   = 32,
    parameter int FAIL_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        int_tick,
    input  logic        ext_tick,
    input  logic        ext_fail,
    output logic        tick_out,
    output logic        gated_out
);

    ctrl_t             ctrl;
    logic [NDIV_W-1:0] ndiv;
    logic              ndiv_wr;
    logic              gate_en;
    logic              trip;
    logic              div_pulse;
    logic              src_pick;

    lsclk_regs #(.DATA_W(32), .NW(NDIV_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .trip    (trip),
        .ctrl    (ctrl),
        .ndiv    (ndiv),
        .ndiv_wr (ndiv_wr),
        .gate_en (gate_en),
        .rdata   (bus_rdata)
    );

    lsclk_fail_mon #(.FAIL_CYCLES(FAIL_CYCLES)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_ext  (ctrl.src_ext),
        .bypass   (ctrl.bypass),
        .ext_fail (ext_fail),
        .trip     (trip)
    );

    lsclk_divider #(.FIXED_DIV(FIXED_DIV), .NW(NDIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_tick   (int_tick),
        .ndiv      (ndiv),
        .ndiv_wr   (ndiv_wr),
        .div_pulse (div_pulse)
    );

    assign src_pick = ctrl.src_ext ? (ext_tick && ctrl.ext_en) : div_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_out  <= 1'b0;
            gated_out <= 1'b0;
        end else begin
            tick_out  <= src_pick;
            gated_out <= src_pick && gate_en;
        end
    end

    // R5: external strobe passes with one cycle of latency
    a_r5_ext_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.src_ext && ctrl.ext_en) |=> (tick_out == $past(ext_tick)));

    // R5: a disabled crystal yields no ticks
    a_r5_ext_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.src_ext && !ctrl.ext_en) |=> !tick_out);

    // R8: the gated copy never fires on its own
    a_r8_gate_subset: assert property (@(posedge clk) disable iff (!rst_n)
        gated_out |-> tick_out);

    // R7: bypass holds the external selection against failures
    a_r7_bypass_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.src_ext && ctrl.bypass && !(bus_wr && bus_addr == ADR_CTRL)) |=> ctrl.src_ext);

endmodule

// File: tb/lsclk_select_test.sv
module lsclk_select_test;

    localparam int PRE   = 32;
    localparam int FAILN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        int_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        ext_fail = 1'b0;
    logic        tick_out;
    logic        gated_out;

    always #4 clk = ~clk;

    lsclk_select #(.FIXED_DIV(PRE), .FAIL_CYCLES(FAILN)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .int_tick  (int_tick),
        .ext_tick  (ext_tick),
        .ext_fail  (ext_fail),
        .tick_out  (tick_out),
        .gated_out (gated_out)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bit m_sel, m_en, m_byp, m_gate, m_tick, m_gated, used_ext;
    int m_n, m_pre, m_div, m_fcnt;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mread(logic [1:0] a);
        logic [31:0] v = '0;
        case (a)
            2'd0: begin v[0] = m_sel; v[4] = m_en; v[15] = m_byp; end
            2'd1: v[4:0] = m_n[4:0];
            2'd2: v[0] = m_gate;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic model(bit w, logic [1:0] a, logic [31:0] d, bit i, bit e, bit f);
        bit pre_p, div_p, src, armed, trip;
        pre_p    = i && (m_pre == PRE - 1);
        div_p    = pre_p && (m_div == m_n);
        used_ext = m_sel;
        src      = m_sel ? (e && m_en) : div_p;
        m_tick   = src;
        m_gated  = src && m_gate;
        armed    = m_sel && !m_byp;
        trip     = armed && f && (m_fcnt + 1 == FAILN);
        m_fcnt   = (armed && f && !trip) ? m_fcnt + 1 : 0;
        if (i) m_pre = (m_pre == PRE - 1) ? 0 : m_pre + 1;
        if (w && a == 2'd1) m_div = 0;
        else if (pre_p) m_div = (m_div == m_n) ? 0 : m_div + 1;
        if (w && a == 2'd0 && d[31:16] == 16'h16AA) begin
            m_sel = d[0]; m_en = d[4]; m_byp = d[15];
        end else if (trip) begin
            m_sel = 1'b0;
        end
        if (w && a == 2'd1) m_n = int'(d[4:0]);
        if (w && a == 2'd2) m_gate = d[0];
    endtask

    task automatic cyc(bit w, logic [1:0] a, logic [31:0] d, bit i, bit e, bit f);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        int_tick = i; ext_tick = e; ext_fail = f;
        @(posedge clk);
        model(w, a, d, i, e, f);
        @(negedge clk);
        chk(used_ext ? "R5" : "R3", {31'd0, tick_out}, {31'd0, m_tick});
        chk("R8", {31'd0, gated_out}, {31'd0, m_gated});
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, string req);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        chk(req, bus_rdata, mread(a));
    endtask

    initial begin
        int pulses;
        void'($urandom(32'd20240611));
        m_sel = 0; m_en = 0; m_byp = 0; m_gate = 0;
        m_n = 0; m_pre = 0; m_div = 0; m_fcnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1", {30'd0, tick_out, gated_out}, 32'd0);
        rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");
        rd(2'd3, "R2");

        // R2 bad key ignored, masked readback
        cyc(1, 2'd0, 32'h1234_8011, 0, 0, 0);
        rd(2'd0, "R2");
        chk("R2", bus_rdata, 32'd0);
        cyc(1, 2'd1, 32'hFFFF_FFE3, 0, 0, 0);
        rd(2'd1, "R2");
        chk("R2", bus_rdata, 32'd3);
        cyc(1, 2'd2, 32'hFFFF_FFFF, 0, 0, 0);
        rd(2'd2, "R2");

        // R3 internal rate: 32*(3+1) = 128 strobes per tick
        pulses = 0;
        for (int k = 0; k < 1024; k++) begin
            cyc(0, 2'd0, 0, 1, 0, 0);
            if (tick_out) pulses++;
        end
        chk("R3", pulses, 8);

        // R4 divider rewrite mid-count
        for (int k = 0; k < 70; k++) cyc(0, 2'd0, 0, 1, 0, 0);
        cyc(1, 2'd1, 32'd0, 1, 0, 0);
        for (int k = 0; k < 100; k++) cyc(0, 2'd0, 0, 1, 0, 0);
        rd(2'd1, "R4");

        // R5 external without enable, then with enable
        cyc(1, 2'd0, 32'h16AA_0001, 0, 0, 0);
        rd(2'd0, "R2");
        for (int k = 0; k < 20; k++) cyc(0, 2'd0, 0, 1, 1, 0);
        cyc(1, 2'd0, 32'h16AA_0011, 0, 0, 0);
        for (int k = 0; k < 40; k++) cyc(0, 2'd0, 0, $urandom % 2, $urandom % 2, 0);

        // R10 short and broken runs
        for (int k = 0; k < FAILN - 1; k++) cyc(0, 2'd0, 0, 0, 1, 1);
        cyc(0, 2'd0, 0, 0, 1, 0);
        for (int k = 0; k < FAILN - 1; k++) cyc(0, 2'd0, 0, 0, 1, 1);
        cyc(0, 2'd0, 0, 0, 1, 0);
        rd(2'd0, "R10");
        chk("R10", bus_rdata, 32'h0000_0011);

        // R6 full run triggers fallback at the last edge
        for (int k = 0; k < FAILN - 1; k++) cyc(0, 2'd0, 0, 0, 1, 1);
        rd(2'd0, "R6");
        chk("R6", bus_rdata, 32'h0000_0011);
        cyc(0, 2'd0, 0, 0, 1, 1);
        rd(2'd0, "R6");
        chk("R6", bus_rdata, 32'h0000_0010);
        cyc(0, 2'd0, 0, 1, 1, 0);

        // R7 bypass prevents fallback
        cyc(1, 2'd0, 32'h16AA_8011, 0, 0, 0);
        for (int k = 0; k < 3 * FAILN; k++) cyc(0, 2'd0, 0, 0, 1, 1);
        rd(2'd0, "R7");
        chk("R7", bus_rdata, 32'h0000_8011);

        // R9 keyed write on the trip edge wins
        cyc(1, 2'd0, 32'h16AA_0011, 0, 0, 0);
        for (int k = 0; k < FAILN - 1; k++) cyc(0, 2'd0, 0, 0, 1, 1);
        cyc(1, 2'd0, 32'h16AA_0011, 0, 1, 1);
        rd(2'd0, "R9");
        chk("R9", bus_rdata, 32'h0000_0011);
        cyc(0, 2'd0, 0, 0, 1, 0);

        // mixed random traffic against the model
        for (int k = 0; k < 6000; k++) begin
            bit w;
            logic [1:0] a;
            logic [31:0] d;
            w = ($urandom % 24) == 0;
            a = 2'($urandom % 4);
            d = $urandom;
            if (($urandom % 4) != 0) d[31:16] = 16'h16AA;
            cyc(w, a, d, ($urandom % 3) != 0, ($urandom % 2) == 0, ($urandom % 5) != 0);
            if ((k % 97) == 0) rd(2'($urandom % 4), "R2");
        end
        rd(2'd0, "R6");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule